// File: doc/BRIEF.md
# Smart Card Contact Power Sequencer

This block sits on the host side of a smart card contact set and brings the card's supplies and signals up and down in a fixed order. A falling edge on the active-low host command line starts a staged power-up. The charge pump is enabled first, then the card regulator, then the I/O level translators. After that the card clock is gated on and the card reset is released. A rising command line or any fault flag starts a staged power-down. That power-down runs in the reverse order with its own fixed offsets, and the block then returns to its idle wait state.

All offsets are counted in microseconds. The microsecond tick comes from a divider on the system clock. The host reset request only matters once the translators have been on for a short settling time. When that request is low at that point, or falls later, the card clock starts early. Otherwise the clock starts together with the reset release. From the release onward, the card reset line copies the host request. The analog supplies, the level shifting and the clock divider sit outside the block; this block drives only their enables.

Top module: `card_pwr_seq`

## Requirements
- R1: A power-up starts only on a high-to-low transition of `cmd_n_i` seen while all bits of `fault_i` are zero. A falling command edge while any fault bit is set is ignored.
- R2: Let E be the clock edge that first samples the command low. `pump_en_o`, `reg_en_o` and `io_en_o` rise at edge E + T·CLK_MHZ + 1, with T = T_PUMP, T_REG and T_IO respectively.
- R3: `rst_req_i` is ignored until ceil(ARM_NS·CLK_MHZ/1000) clock cycles after `io_en_o` rises. A low pulse before that time does not start the card clock.
- R4: After that settling time and before the release, `clk_en_o` rises at the edge that first samples `rst_req_i` low.
- R5: At edge E + T_REL·CLK_MHZ + 1, `clk_en_o` is high. At that same edge `card_rst_o` takes the sampled value of `rst_req_i`.
- R6: After the release, `card_rst_o` copies `rst_req_i` with one register of delay.
- R7: Let F be the edge that samples `cmd_n_i` high during power-up or operation. `card_rst_o` falls at F. `clk_en_o`, `io_en_o`, `reg_en_o` and `pump_en_o` fall at F + T·CLK_MHZ + 1, with T = T_CLKOFF, T_IOOFF, T_REGOFF and T_PMPOFF respectively.
- R8: Any set bit of `fault_i` during power-up or operation starts the same power-down, with the same offsets measured from the edge that samples the fault. During power-up this aborts the sequence, and enables not yet on stay off.
- R9: No output changes except as listed above. In the wait state all five card-side outputs are low. At all times clk_en implies io_en, io_en implies reg_en, reg_en implies pump_en, and card_rst implies clk_en.
- R10: `ready_o` is high exactly when every bit of `fault_i` is zero.
- R11: After a power-down, a new power-up needs `cmd_n_i` to return high and then fall again. A command held low through the power-down does not restart the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_n_i | input | 1 | Host command, low requests card power |
| rst_req_i | input | 1 | Host card-reset request |
| fault_i | input | NFLT | Fault flags: 0 card absent, 1 supply low, 2 overtemperature, 3 regulator fault, 4 pump low |
| pump_en_o | output | 1 | Charge pump enable |
| reg_en_o | output | 1 | Card regulator enable |
| io_en_o | output | 1 | I/O translator enable |
| clk_en_o | output | 1 | Card clock gate |
| card_rst_o | output | 1 | Card reset line |
| ready_o | output | 1 | No fault present |

## Verification
Each staged output is due at a cycle that the bench computes from the edge that sampled the trigger. That cycle is the trigger edge plus the offset in microseconds times the tick divisor plus one register. The clock-gating cases add the settling count plus one cycle after the translators come on. Each follow-the-request reset change is due one edge after the new request value is sampled. The driver pushes every expected output change, with its exact cycle, into an ordered queue before that cycle arrives. A monitor samples on the falling clock edge and matches each observed change against the head of the queue. Any change that was not expected fails, as does any expected change left in the queue at the end.

// File: rtl/cps_pkg.sv
package cps_pkg;

   typedef enum logic [1:0] {
      ST_WAIT  = 2'd0,
      ST_ACT   = 2'd1,
      ST_ON    = 2'd2,
      ST_DEACT = 2'd3
   } cps_state_e;

   function automatic int cps_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cps_usec_tick.sv
// Microsecond strobe, restartable so offsets count from a known edge.
module cps_usec_tick #(
   parameter int DIV = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   output logic tick_o
);
   generate
      if (DIV <= 1) begin : g_every
         assign tick_o = 1'b1;
      end else begin : g_div
         localparam int W = $clog2(DIV);
         localparam logic [W-1:0] LAST = W'(DIV - 1);
         logic [W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              div_q <= '0;
            else if (restart_i)      div_q <= '0;
            else if (div_q == LAST)  div_q <= '0;
            else                     div_q <= div_q + 1'b1;
         end
         assign tick_o = (div_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/cps_us_timer.sv
// Saturating count of microseconds since the last restart.
module cps_us_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart_i,
   input  logic         tick_i,
   output logic [W-1:0] us_o
);
   localparam logic [W-1:0] TOP = '1;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      us_o <= '0;
      else if (restart_i)              us_o <= '0;
      else if (tick_i && us_o != TOP)  us_o <= us_o + 1'b1;
   end
endmodule

// File: rtl/cps_req_arm.sv
// Opens the window in which the host reset request is honoured.
module cps_req_arm #(
   parameter int ARM_CYC = 75
) (
   input  logic clk,
   input  logic rst_n,
   input  logic io_on_i,
   output logic armed_o
);
   generate
      if (ARM_CYC == 0) begin : g_now
         assign armed_o = io_on_i;
      end else begin : g_count
         localparam int W = $clog2(ARM_CYC + 1);
         localparam logic [W-1:0] LIM = W'(ARM_CYC);
         logic [W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt_q <= '0;
            else if (!io_on_i)     cnt_q <= '0;
            else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
         end
         assign armed_o = io_on_i && (cnt_q == LIM);
      end
   endgenerate
endmodule

// File: rtl/card_pwr_seq.sv
module card_pwr_seq
   import cps_pkg::*;
#(
   parameter int NFLT     = 5,
   parameter int CLK_MHZ  = 250,
   parameter int ARM_NS   = 300,
   parameter int T_PUMP   = 21,
   parameter int T_REG    = 57,
   parameter int T_IO     = 116,
   parameter int T_REL    = 187,
   parameter int T_CLKOFF = 12,
   parameter int T_IOOFF  = 24,
   parameter int T_REGOFF = 36,
   parameter int T_PMPOFF = 118
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_n_i,
   input  logic            rst_req_i,
   input  logic [NFLT-1:0] fault_i,
   output logic            pump_en_o,
   output logic            reg_en_o,
   output logic            io_en_o,
   output logic            clk_en_o,
   output logic            card_rst_o,
   output logic            ready_o
);
   localparam int ARM_CYC = (ARM_NS * CLK_MHZ + 999) / 1000;
   localparam int T_TOP   = cps_max(T_REL, T_PMPOFF);
   localparam int US_W    = $clog2(T_TOP + 2);

   localparam logic [US_W-1:0] C_PUMP   = US_W'(T_PUMP);
   localparam logic [US_W-1:0] C_REG    = US_W'(T_REG);
   localparam logic [US_W-1:0] C_IO     = US_W'(T_IO);
   localparam logic [US_W-1:0] C_REL    = US_W'(T_REL);
   localparam logic [US_W-1:0] C_CLKOFF = US_W'(T_CLKOFF);
   localparam logic [US_W-1:0] C_IOOFF  = US_W'(T_IOOFF);
   localparam logic [US_W-1:0] C_REGOFF = US_W'(T_REGOFF);
   localparam logic [US_W-1:0] C_PMPOFF = US_W'(T_PMPOFF);

   generate
      if (NFLT < 1) begin : g_bad_nflt
         $error("NFLT must be at least 1");
      end
      if (CLK_MHZ < 1) begin : g_bad_clk
         $error("CLK_MHZ must be at least 1");
      end
      if (!(T_PUMP < T_REG && T_REG < T_IO && T_IO < T_REL)) begin : g_bad_up
         $error("power-up offsets must strictly increase");
      end
      if (!(T_CLKOFF < T_IOOFF && T_IOOFF < T_REGOFF && T_REGOFF < T_PMPOFF)) begin : g_bad_dn
         $error("power-down offsets must strictly increase");
      end
   endgenerate

   cps_state_e      state_q;
   logic            cmd_q;
   logic            any_fault, trig, start, abort, restart;
   logic            tick, armed;
   logic [US_W-1:0] us;
   logic            pump_q, reg_q, io_q, clk_q, rst_q;

   assign any_fault = |fault_i;
   assign trig      = cmd_n_i | any_fault;
   assign start     = (state_q == ST_WAIT) && cmd_q && !cmd_n_i && !any_fault;
   assign abort     = ((state_q == ST_ACT) || (state_q == ST_ON)) && trig;
   assign restart   = start | abort;

   cps_usec_tick #(.DIV(CLK_MHZ)) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart),
      .tick_o    (tick)
   );

   cps_us_timer #(.W(US_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart),
      .tick_i    (tick),
      .us_o      (us)
   );

   cps_req_arm #(.ARM_CYC(ARM_CYC)) u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .io_on_i (io_q),
      .armed_o (armed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_q <= 1'b1;
      else        cmd_q <= cmd_n_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_WAIT;
         pump_q  <= 1'b0;
         reg_q   <= 1'b0;
         io_q    <= 1'b0;
         clk_q   <= 1'b0;
         rst_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_WAIT: begin
               if (start) state_q <= ST_ACT;
            end
            ST_ACT: begin
               if (trig) begin
                  state_q <= ST_DEACT;
                  rst_q   <= 1'b0;
               end else begin
                  if (us >= C_PUMP) pump_q <= 1'b1;
                  if (us >= C_REG)  reg_q  <= 1'b1;
                  if (us >= C_IO)   io_q   <= 1'b1;
                  if (armed && !rst_req_i) clk_q <= 1'b1;
                  if (us >= C_REL) begin
                     state_q <= ST_ON;
                     clk_q   <= 1'b1;
                     rst_q   <= rst_req_i;
                  end
               end
            end
            ST_ON: begin
               if (trig) begin
                  state_q <= ST_DEACT;
                  rst_q   <= 1'b0;
               end else begin
                  rst_q <= rst_req_i;
               end
            end
            ST_DEACT: begin
               rst_q <= 1'b0;
               if (us >= C_CLKOFF) clk_q <= 1'b0;
               if (us >= C_IOOFF)  io_q  <= 1'b0;
               if (us >= C_REGOFF) reg_q <= 1'b0;
               if (us >= C_PMPOFF) begin
                  pump_q  <= 1'b0;
                  state_q <= ST_WAIT;
               end
            end
            default: state_q <= ST_WAIT;
         endcase
      end
   end

   assign pump_en_o  = pump_q;
   assign reg_en_o   = reg_q;
   assign io_en_o    = io_q;
   assign clk_en_o   = clk_q;
   assign card_rst_o = rst_q;
   assign ready_o    = !any_fault;

endmodule

// File: rtl/cps_chk.sv
module cps_chk #(
   parameter int NFLT = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_n_i,
   input logic [NFLT-1:0] fault_i,
   input logic            pump_en_o,
   input logic            reg_en_o,
   input logic            io_en_o,
   input logic            clk_en_o,
   input logic            card_rst_o
);
   // R9
   reg_needs_pump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_en_o |-> pump_en_o);
   // R9
   io_needs_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_en_o |-> reg_en_o);
   // R9
   clk_needs_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_o |-> io_en_o);
   // R9
   rst_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_rst_o |-> clk_en_o);
   // R1
   pump_start_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pump_en_o) |-> (!$past(cmd_n_i) && ($past(fault_i) == '0)));
   // R7
   cmd_drops_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_n_i |=> !card_rst_o);
   // R8
   fault_drops_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|fault_i) |=> !card_rst_o);
endmodule

bind card_pwr_seq cps_chk #(.NFLT(NFLT)) u_cps_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_n_i    (cmd_n_i),
   .fault_i    (fault_i),
   .pump_en_o  (pump_en_o),
   .reg_en_o   (reg_en_o),
   .io_en_o    (io_en_o),
   .clk_en_o   (clk_en_o),
   .card_rst_o (card_rst_o)
);

// File: tb/card_pwr_seq_bench.sv
module card_pwr_seq_bench;
   // Timing scaled: one microsecond tick every D system clocks.
   localparam int D    = 4;
   localparam int AC   = 2;   // ceil(300 * 4 / 1000)
   localparam int TP   = 21, TR = 57, TI = 116, TL = 187;
   localparam int TCO  = 12, TIO = 24, TRO = 36, TPO = 118;
   localparam int WD   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_n = 1'b1;
   logic       rst_req = 1'b1;
   logic [4:0] fault = '0;
   logic       pump_en_o, reg_en_o, io_en_o, clk_en_o, card_rst_o, ready_o;

   int cyc = 0;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   typedef struct {
      int    sig;
      bit    val;
      int    at;
      string req;
   } ev_t;
   ev_t evq[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   card_pwr_seq #(.CLK_MHZ(D)) u_card_pwr_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_n_i    (cmd_n),
      .rst_req_i  (rst_req),
      .fault_i    (fault),
      .pump_en_o  (pump_en_o),
      .reg_en_o   (reg_en_o),
      .io_en_o    (io_en_o),
      .clk_en_o   (clk_en_o),
      .card_rst_o (card_rst_o),
      .ready_o    (ready_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic push(input int s, input bit v, input int at, input string req);
      ev_t e;
      e.sig = s; e.val = v; e.at = at; e.req = req;
      evq.push_back(e);
   endtask

   task automatic step_to(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic expect_up(input int e, input string req);
      push(0, 1'b1, e + TP * D + 1, req);
      push(1, 1'b1, e + TR * D + 1, req);
      push(2, 1'b1, e + TI * D + 1, req);
   endtask

   task automatic expect_down(input int f, input bit rst_on, input bit clk_on,
                              input string req);
      if (rst_on) push(4, 1'b0, f, req);
      if (clk_on) push(3, 1'b0, f + TCO * D + 1, req);
      push(2, 1'b0, f + TIO * D + 1, req);
      push(1, 1'b0, f + TRO * D + 1, req);
      push(0, 1'b0, f + TPO * D + 1, req);
   endtask

   // Monitor: pops and compares each observed output change.
   logic [4:0] mon_prev = '0;
   logic [4:0] mon_now;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         mon_now = {card_rst_o, clk_en_o, io_en_o, reg_en_o, pump_en_o};
         for (int s = 0; s < 5; s++) begin
            if (mon_now[s] != mon_prev[s]) begin
               if (evq.size() == 0) begin
                  checks++; fails++;
                  $display("FAIL R9: output %0d changed to %0d at cycle %0d, expected no change",
                           s, mon_now[s], cyc);
               end else begin
                  ev_t e;
                  e = evq.pop_front();
                  checks++;
                  if (e.sig != s || e.val != mon_now[s] || e.at != cyc) begin
                     fails++;
                     $display("FAIL %s: got output %0d=%0d at cycle %0d, expected output %0d=%0d at cycle %0d",
                              e.req, s, mon_now[s], cyc, e.sig, e.val, e.at);
                  end
               end
            end
         end
         mon_prev = mon_now;
      end
      if (!done && cyc >= WD) begin
         done = 1'b1;
         fails++; checks++;
         $display("FAIL watchdog: got cycle %0d expected finish before %0d", cyc, WD);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int e, f, g, h, i;
      step_to(5);
      rst_n = 1'b1;
      step_to(8);
      // R9 reset state, R10 ready with no faults
      check("R9", {card_rst_o, clk_en_o, io_en_o, reg_en_o, pump_en_o}, 0);
      check("R10", ready_o, 1);

      // T1: request held high, clock and reset come at release (R2, R5, R7)
      cmd_n = 1'b0; e = cyc + 1;
      expect_up(e, "R2");
      push(3, 1'b1, e + TL * D + 1, "R5");
      push(4, 1'b1, e + TL * D + 1, "R5");
      step_to(e + TL * D + 10);
      check("R5", card_rst_o, 1);
      cmd_n = 1'b1; f = cyc + 1;
      expect_down(f, 1'b1, 1'b1, "R7");
      step_to(f + TPO * D + 10);

      // T2: request low from the start, then toggled after release (R4, R6)
      rst_req = 1'b0;
      cmd_n = 1'b0; e = cyc + 1;
      expect_up(e, "R2");
      push(3, 1'b1, e + TI * D + 1 + AC + 1, "R4");
      step_to(e + TL * D + 10);
      check("R5", card_rst_o, 0);
      rst_req = 1'b1; push(4, 1'b1, cyc + 1, "R6");
      step_to(cyc + 5);
      rst_req = 1'b0; push(4, 1'b0, cyc + 1, "R6");
      step_to(cyc + 5);
      rst_req = 1'b1; push(4, 1'b1, cyc + 1, "R6");
      step_to(cyc + 5);
      cmd_n = 1'b1; f = cyc + 1;
      expect_down(f, 1'b1, 1'b1, "R7");
      step_to(f + TPO * D + 10);

      // T3: early low pulse ignored (R3), later low starts clock (R4), fault in operation (R8)
      rst_req = 1'b1;
      cmd_n = 1'b0; e = cyc + 1;
      expect_up(e, "R2");
      i = e + TI * D + 1;
      step_to(i);
      rst_req = 1'b0;
      step_to(i + 1);
      rst_req = 1'b1;
      step_to(i + 20);
      check("R3", clk_en_o, 0);
      rst_req = 1'b0; g = cyc + 1;
      push(3, 1'b1, g, "R4");
      step_to(e + TL * D + 10);
      check("R5", card_rst_o, 0);
      fault = 5'b00100; f = cyc + 1;
      expect_down(f, 1'b0, 1'b1, "R8");
      #1;
      check("R10", ready_o, 0);
      step_to(cyc + 1);
      fault = '0;
      step_to(f + TPO * D + 10);
      check("R11", pump_en_o, 0);
      cmd_n = 1'b1;
      step_to(cyc + 5);

      // T4: fault aborts power-up after the pump is on (R8)
      rst_req = 1'b1;
      cmd_n = 1'b0; e = cyc + 1;
      push(0, 1'b1, e + TP * D + 1, "R2");
      step_to(e + 30 * D);
      fault = 5'b10000; f = cyc + 1;
      push(0, 1'b0, f + TPO * D + 1, "R8");
      step_to(cyc + 1);
      fault = '0;
      step_to(f + TPO * D + 10);
      check("R8", {reg_en_o, io_en_o}, 0);
      cmd_n = 1'b1;
      step_to(cyc + 5);

      // T5: falling command while a fault is present is ignored (R1, R10)
      fault = 5'b00001;
      #1;
      check("R10", ready_o, 0);
      cmd_n = 1'b0;
      step_to(cyc + 30 * D);
      check("R1", pump_en_o, 0);
      cmd_n = 1'b1;
      step_to(cyc + 2);
      fault = '0;
      #1;
      check("R10", ready_o, 1);
      step_to(cyc + 3);

      // T6: early cancel, command falls again during power-down (R11)
      cmd_n = 1'b0; e = cyc + 1;
      step_to(e + 10 * D);
      cmd_n = 1'b1; f = cyc + 1;
      step_to(f + 50 * D);
      cmd_n = 1'b0;
      step_to(f + TPO * D + 40);
      check("R11", pump_en_o, 0);
      cmd_n = 1'b1;
      step_to(cyc + 5);
      cmd_n = 1'b0; h = cyc + 1;
      expect_up(h, "R11");
      push(3, 1'b1, h + TL * D + 1, "R5");
      push(4, 1'b1, h + TL * D + 1, "R5");
      step_to(h + TL * D + 10);
      cmd_n = 1'b1; f = cyc + 1;
      expect_down(f, 1'b1, 1'b1, "R7");
      step_to(f + TPO * D + 10);

      check("R9", evq.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule